// File: doc/BRIEF.md
# Inbound DMA Address Window Translator

This block sits on the inbound DMA path of an I/O bridge. It turns a 64-bit address issued by a device on the downstream bus into a system target address. The device address space is cut into five windows. Two windows map directly: a 64-bit window that passes address bits through, and a 32-bit window that adds a per-port base. Three windows go through page tables: a 32-bit window, a 40-bit window with 64 MB pages, and a 40-bit super-page window with 16 GB pages. In some windows the address itself carries a barrier attribute and an MSI attribute. The bit that holds each one depends on the window.

Each lookup presents an address and a port number. One cycle later the block returns the target address, the barrier and MSI attributes, and a hit or fault flag. Firmware loads the two page tables and the two direct-map base registers through a simple write port. The 32-bit table window and the super-page window share one table. Its first 64 entries are the super pages: 32 for each port.

Top module: `dma_window_xlat`

## Requirements
- R1: An address with bit 63 set hits in the direct 64-bit window. The target is the address bits 53:0 with bits 63:54 zero. The barrier output is address bit 62 and the MSI output is address bit 61.
- R2: An address from 0x8000_0000 to 0xFFFF_FFFF hits in the direct 32-bit window. The target is the direct-map base of the selected port (`lk_port`) ORed with address bits 29:0. The barrier output is address bit 30 and MSI is 0.
- R3: An address from 0 to 0x7FFF_FFFF uses the shared table. Address bit 30 is the barrier output and is removed before translation. The index is address bits 29:18 (256 KB pages). The target is the entry page address (entry bits 61:18) followed by address bits 17:0.
- R4: An address from 0x40_0000_0000 to 0x7F_FFFF_FFFF uses the wide table. The index is address bits 37:26 (64 MB pages). The target is entry bits 61:26 followed by address bits 25:0. Barrier is always 0.
- R5: An address from 0x80_0000_0000 to 0xFF_FFFF_FFFF uses the shared table with 16 GB pages. The index is 32×`lk_port` + address bits 38:34. The target is entry bits 61:34 followed by address bits 33:0. Barrier is always 0.
- R6: A table entry is valid when bit 63 is set. Bit 62 is the MSI output for a table hit. Target bits 63:62 are always zero for a table hit.
- R7: A table lookup faults when the entry is invalid or the index is past the end of its table. A fault gives `rsp_fault`=1, `rsp_hit`=0, target 0, barrier 0 and MSI 0.
- R8: An address in none of the five windows gives hit 0, fault 0, target 0 and both attributes 0.
- R9: After reset `rsp_valid` is 0, every table entry is invalid and both direct-map bases are zero.
- R10: Every response appears on the cycle after its lookup, with `rsp_valid` = the previous `lk_valid`. A table write in the same cycle as a lookup is not seen by that lookup.
- R11: On a write (`cfg_we`=1), `cfg_sel` picks the target:
  - 0 writes shared-table entry `cfg_idx`.
  - 1 writes wide-table entry `cfg_idx`.
  - 2 writes direct-map base `cfg_idx[0]`, with data bits 29:0 forced to zero.
  - 3 is ignored.
  - A write whose index is past the end of its table is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Device bus address |
| lk_port | input | 1 | Requesting port (0 or 1) |
| cfg_we | input | 1 | Write strobe for tables and bases |
| cfg_sel | input | 2 | Write target select |
| cfg_idx | input | 12 | Entry index, or port for a base write |
| cfg_data | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 64 | Translated target address |
| rsp_barrier | output | 1 | Barrier attribute |
| rsp_msi | output | 1 | MSI attribute |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Table lookup hit an invalid or missing entry |

## Verification
The properties assume that `lk_addr` and `lk_port` are known whenever `lk_valid` is high. They also assume that `lk_valid` is low during reset, so the one-cycle response relation never points at a request made before reset. The stimulus drives every input on the falling edge and holds it there. It clears `lk_valid` between bursts, and it never leaves the address or port undriven while a lookup is active. Table contents are written by the bench with aligned page addresses, so the expected targets can be written as plain constants.

// File: rtl/dma_window_xlat.sv
module dma_window_xlat #(
  parameter int SHARED_ENTRIES = 128,
  parameter int WIDE_ENTRIES   = 64,
  parameter int SUPER_PER_PORT = 32,
  parameter int SHARED_SHIFT   = 18,
  parameter int WIDE_SHIFT     = 26,
  parameter int SUPER_SHIFT    = 34,
  parameter int IDX_W          = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [63:0]      lk_addr,
  input  logic             lk_port,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [63:0]      cfg_data,
  output logic             rsp_valid,
  output logic [63:0]      rsp_addr,
  output logic             rsp_barrier,
  output logic             rsp_msi,
  output logic             rsp_hit,
  output logic             rsp_fault
);
  localparam int SIW = $clog2(SHARED_ENTRIES);
  localparam int WIW = $clog2(WIDE_ENTRIES);
  localparam logic [63:0] SH_MASK = (64'd1 << SHARED_SHIFT) - 64'd1;
  localparam logic [63:0] WD_MASK = (64'd1 << WIDE_SHIFT) - 64'd1;
  localparam logic [63:0] SP_MASK = (64'd1 << SUPER_SHIFT) - 64'd1;

  logic [63:0] shared_tab [SHARED_ENTRIES];
  logic [63:0] wide_tab   [WIDE_ENTRIES];
  logic [63:0] dmap       [2];

  wire a = 1'b0;
  wire in_d64 = lk_addr[63];
  wire in_d32 = (lk_addr[63:32] == '0) && lk_addr[31];
  wire in_t32 = (lk_addr[63:31] == '0);
  wire in_t40 = (lk_addr[63:39] == '0) && lk_addr[38];
  wire in_sp  = (lk_addr[63:40] == '0) && lk_addr[39];

  wire [63:0] t32_idx = {34'd0, lk_addr[29:0]} >> SHARED_SHIFT;
  wire [63:0] t40_idx = {26'd0, lk_addr[37:0]} >> WIDE_SHIFT;
  wire [63:0] sp_sub  = {25'd0, lk_addr[38:0]} >> SUPER_SHIFT;
  wire [SIW-1:0] sp_idx = sp_sub[SIW-1:0] + (lk_port ? SIW'(SUPER_PER_PORT) : '0);

  wire [SIW-1:0] sh_sel = in_sp ? sp_idx : t32_idx[SIW-1:0];
  wire [63:0] entry = in_t40 ? wide_tab[t40_idx[WIW-1:0]] : shared_tab[sh_sel];
  wire ent_ok = in_t40 ? (t40_idx < 64'(WIDE_ENTRIES)) :
                in_sp  ? (sp_sub < 64'(SUPER_PER_PORT)) :
                         (t32_idx < 64'(SHARED_ENTRIES));
  wire [63:0] pmask = in_sp ? SP_MASK : in_t40 ? WD_MASK : SH_MASK;

  logic [63:0] n_addr;
  logic n_bar, n_msi, n_hit, n_fault;

  always_comb begin
    n_addr = '0; n_bar = 1'b0; n_msi = 1'b0; n_hit = 1'b0; n_fault = a;
    if (in_d64) begin
      n_hit  = 1'b1;
      n_addr = {10'd0, lk_addr[53:0]};
      n_bar  = lk_addr[62];
      n_msi  = lk_addr[61];
    end else if (in_d32) begin
      n_hit  = 1'b1;
      n_addr = dmap[lk_port] | {34'd0, lk_addr[29:0]};
      n_bar  = lk_addr[30];
    end else if (in_t32 || in_t40 || in_sp) begin
      if (!ent_ok || !entry[63]) begin
        n_fault = 1'b1;
      end else begin
        n_hit  = 1'b1;
        n_addr = ({2'b00, entry[61:0]} & ~pmask) | (lk_addr & pmask);
        n_msi  = entry[62];
        n_bar  = in_t32 & lk_addr[30];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SHARED_ENTRIES; i++) shared_tab[i] <= '0;
      for (int i = 0; i < WIDE_ENTRIES; i++) wide_tab[i] <= '0;
      dmap[0] <= '0;
      dmap[1] <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: if (cfg_idx < IDX_W'(SHARED_ENTRIES)) shared_tab[cfg_idx[SIW-1:0]] <= cfg_data;
        2'd1: if (cfg_idx < IDX_W'(WIDE_ENTRIES)) wide_tab[cfg_idx[WIW-1:0]] <= cfg_data;
        2'd2: dmap[cfg_idx[0]] <= {cfg_data[63:30], 30'd0};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_addr <= '0; rsp_barrier <= 1'b0;
      rsp_msi <= 1'b0; rsp_hit <= 1'b0; rsp_fault <= 1'b0;
    end else begin
      rsp_valid   <= lk_valid;
      rsp_addr    <= n_addr;
      rsp_barrier <= n_bar;
      rsp_msi     <= n_msi;
      rsp_hit     <= n_hit;
      rsp_fault   <= n_fault;
    end
  end
endmodule

module dma_window_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [63:0] lk_addr,
  input logic        rsp_valid,
  input logic [63:0] rsp_addr,
  input logic        rsp_barrier,
  input logic        rsp_msi,
  input logic        rsp_hit,
  input logic        rsp_fault
);
  wire gap = (!lk_addr[63] && lk_addr[62:40] != '0) ||
             (lk_addr[63:40] == '0 && lk_addr[39:38] == 2'b00 && lk_addr[37:32] != '0);

  p_fault_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_addr == '0 && !rsp_hit && !rsp_msi && !rsp_barrier));
  p_hit_xor_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  p_direct64_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_addr[63]) |=>
      (rsp_hit && rsp_addr[53:0] == $past(lk_addr[53:0]) && rsp_addr[63:54] == '0
       && rsp_barrier == $past(lk_addr[62]) && rsp_msi == $past(lk_addr[61])));
  p_wide_nobar_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_addr[63:39] == '0 && lk_addr[38]) |=> !rsp_barrier);
  p_super_nobar_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_addr[63:40] == '0 && lk_addr[39]) |=> !rsp_barrier);
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && gap) |=> (!rsp_hit && !rsp_fault && rsp_addr == '0));
endmodule

bind dma_window_xlat dma_window_xlat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_barrier(rsp_barrier),
  .rsp_msi(rsp_msi), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault)
);

// File: tb/sim_dma_window_xlat.sv
`timescale 1ns/1ps
module sim_dma_window_xlat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [63:0] lk_addr = '0;
  logic lk_port = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [11:0] cfg_idx = '0;
  logic [63:0] cfg_data = '0;
  logic rsp_valid, rsp_barrier, rsp_msi, rsp_hit, rsp_fault;
  logic [63:0] rsp_addr;

  always #2 clk = ~clk;

  dma_window_xlat u0 (.*);

  typedef struct packed { logic [63:0] a; logic b; logic m; logic h; logic f; } exp_t;
  exp_t q[$];
  string tq[$];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic lookup(input logic [63:0] addr, input logic port, input logic [63:0] ea,
                        input logic eb, input logic em, input logic eh, input logic ef,
                        input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = addr; lk_port = port;
    q.push_back('{a: ea, b: eb, m: em, h: eh, f: ef});
    tq.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [11:0] idx, input logic [63:0] d);
    @(negedge clk);
    lk_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10: response without request, got valid=1 expected 0");
      end else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        if (rsp_addr !== e.a || rsp_barrier !== e.b || rsp_msi !== e.m ||
            rsp_hit !== e.h || rsp_fault !== e.f) begin
          errors++;
          $display("FAIL %s: got addr=%h b=%b m=%b h=%b f=%b expected addr=%h b=%b m=%b h=%b f=%b",
                   t, rsp_addr, rsp_barrier, rsp_msi, rsp_hit, rsp_fault,
                   e.a, e.b, e.m, e.h, e.f);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      errors++;
      $display("FAIL R9: reset outputs got valid=%b hit=%b expected 0 0", rsp_valid, rsp_hit);
    end
    rst_n = 1'b1;

    // R9: bases zero, tables empty after reset
    lookup(64'h0000_0000_8000_1234, 1'b0, 64'h1234, 0, 0, 1, 0, "R9 zero base");
    lookup(64'h0000_0000_0004_0000, 1'b0, 64'h0, 0, 0, 0, 1, "R9 empty table");
    idle();

    wr(2'd2, 12'd0, 64'h0000_0012_FFFF_FFFF);
    wr(2'd2, 12'd1, 64'h0000_0034_4000_0000);
    wr(2'd0, 12'd65, 64'hC000_0001_2340_0000);
    wr(2'd0, 12'd0,  64'h8000_0014_0000_0000);
    wr(2'd0, 12'd33, 64'h8000_0024_0000_0000);
    wr(2'd0, 12'd70, 64'h4000_0000_0000_1000);
    wr(2'd1, 12'd3,  64'hC000_0000_4800_0000);
    wr(2'd1, 12'd16, 64'h8000_0001_0000_0000);

    // R2 direct 32-bit, base low bits dropped (R11)
    lookup(64'h0000_0000_C000_0ABC, 1'b0, 64'h0000_0012_C000_0ABC, 1, 0, 1, 0, "R2 port0 barrier");
    lookup(64'h0000_0000_8765_4321, 1'b1, 64'h0000_0034_4765_4321, 0, 0, 1, 0, "R2 port1");
    // R1 direct 64-bit
    lookup(64'hE012_3456_789A_BCDE, 1'b0, 64'h0012_3456_789A_BCDE, 1, 1, 1, 0, "R1 attrs set");
    lookup(64'h8000_0000_0000_0040, 1'b1, 64'h40, 0, 0, 1, 0, "R1 attrs clear");
    // R3 / R6 32-bit table
    lookup(64'h0000_0000_4105_2345, 1'b0, 64'h0000_0001_2341_2345, 1, 1, 1, 0, "R3 barrier R6 msi");
    lookup(64'h0000_0000_0105_2345, 1'b1, 64'h0000_0001_2341_2345, 0, 1, 1, 0, "R3 no barrier");
    // R4 wide table
    lookup(64'h0000_0040_0FAB_CDEF, 1'b0, 64'h0000_0000_4BAB_CDEF, 0, 1, 1, 0, "R4 msi page");
    lookup(64'h0000_0040_4000_0005, 1'b0, 64'h0000_0001_0000_0005, 0, 0, 1, 0, "R4 bit30 not barrier");
    // R5 super pages
    lookup(64'h0000_0083_DEAD_BEEF, 1'b0, 64'h0000_0017_DEAD_BEEF, 0, 0, 1, 0, "R5 port0");
    lookup(64'h0000_0084_0000_0010, 1'b1, 64'h0000_0024_0000_0010, 0, 0, 1, 0, "R5 port1");
    lookup(64'h0000_0084_0000_0010, 1'b0, 64'h0, 0, 0, 0, 1, "R5 port0 empty entry");
    // R7 faults
    lookup(64'h0000_0000_0118_0000, 1'b0, 64'h0, 0, 0, 0, 1, "R7 msi-only entry invalid");
    lookup(64'h0000_0041_0000_0000, 1'b0, 64'h0, 0, 0, 0, 1, "R7 wide index past end");
    lookup(64'h0000_0000_0200_0000, 1'b0, 64'h0, 0, 0, 0, 1, "R7 shared index past end");
    // R8 gaps
    lookup(64'h0000_0001_0000_0000, 1'b0, 64'h0, 0, 0, 0, 0, "R8 low gap");
    lookup(64'h0000_0100_0000_0000, 1'b0, 64'h0, 0, 0, 0, 0, "R8 mid gap");
    lookup(64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 64'h0, 0, 0, 0, 0, "R8 top gap");
    idle();

    // R11 out-of-range and unused-select writes ignored
    wr(2'd1, 12'd64,  64'h8000_0000_0000_0000);
    wr(2'd0, 12'd128, 64'h8000_0099_0000_0000);
    wr(2'd3, 12'd0,   64'hFFFF_FFFF_FFFF_FFFF);
    lookup(64'h0000_0040_0000_0000, 1'b0, 64'h0, 0, 0, 0, 1, "R11 wide alias untouched");
    lookup(64'h0000_0083_DEAD_BEEF, 1'b0, 64'h0000_0017_DEAD_BEEF, 0, 0, 1, 0, "R11 shared alias untouched");
    lookup(64'h0000_0000_8000_0000, 1'b0, 64'h0000_0012_C000_0000, 0, 0, 1, 0, "R11 sel3 ignored");
    idle();

    // R10 write and lookup in one cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_idx = 12'd5; cfg_data = 64'h8000_0000_1400_0000;
    lk_valid = 1'b1; lk_addr = 64'h0000_0040_1400_0077; lk_port = 1'b0;
    q.push_back('{a: 64'h0, b: 1'b0, m: 1'b0, h: 1'b0, f: 1'b1});
    tq.push_back("R10 same-cycle write unseen");
    @(negedge clk);
    cfg_we = 1'b0;
    q.push_back('{a: 64'h0000_0000_1400_0077, b: 1'b0, m: 1'b0, h: 1'b1, f: 1'b0});
    tq.push_back("R10 write seen next");
    idle();

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d responses missing, expected 0", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule